// File: doc/BRIEF.md
# VRAM Shift Clock Controller

This block runs on the dot clock and produces two derived clocks for a video pipeline. The first is a free-running video clock for synchronising a graphics processor. The second is a shift clock that reads serial pixel data out of video RAM. Both are square waves at a programmable submultiple of the dot clock. The shift clock follows the video clock during active video. During blanking the shift clock is held off.

A two-bit mode field sets what a dual-purpose flag input does. In split-transfer mode, a rising flag during blanking inserts a single extra shift-clock pulse, so that the RAM can perform a split serial-register transfer. In nibble mode, the flag is sampled when the video clock falls. The sampled value chooses whether the upper or the lower nibble of each pixel-bus byte is captured on the next shift-clock rise. The four captured nibbles are packed into a 16-bit output. Both clock outputs come straight from flops, so they cannot glitch when blank or the divide setting changes.

Top module: `vram_sclk_ctrl`

## Requirements
- R1: `vclk_o` is a 50% square wave with a period of 2·2^d dot-clock cycles, where d = `div_sel_i` (values 5 to 7 act as 4). It keeps running during blanking.
- R2: While `blank_i` is low, `sclk_o` has the same rising edges and high time as `vclk_o`. `sclk_o` is never high while `vclk_o` is low.
- R3: While `blank_i` is high, `sclk_o` has no rising edge other than the extra pulse of R4. In modes 00, 10 and 11 it stays low.
- R4: In mode 01, a rising edge of `flag_i` seen while `blank_i` is high gives exactly one `sclk_o` pulse. The flag first passes through two synchronizing flops. The pulse starts with the next `vclk_o` rise and is high for 2^d dot-clock cycles.
- R5: In mode 01, a flag held high gives a single pulse, and each separate rising edge in the same blanking interval gives its own pulse. A rising edge while `blank_i` is low adds no pulse.
- R6: In mode 10, the synchronized flag is sampled on each falling edge of `vclk_o`. On the next `sclk_o` rise, `nib_o` loads {pix[31:28], pix[23:20], pix[15:12], pix[7:4]} if the sample was high. If the sample was low, it loads {pix[27:24], pix[19:16], pix[11:8], pix[3:0]}.
- R7: `nib_o` changes only on an `sclk_o` rising edge in mode 10. In every other mode it holds its value.
- R8: Mode 11 enables neither split transfer nor nibble capture.
- R9: While `rst_ni` is low, `sclk_o`, `vclk_o` and `nib_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blank_i | input | 1 | Blanking interval active |
| mode_i | input | 2 | Flag mode: 00 ignore, 01 split transfer, 10 nibble, 11 ignore |
| div_sel_i | input | 3 | Log2 of the dot cycles per half period |
| flag_i | input | 1 | Asynchronous split/nibble flag |
| pix_i | input | 32 | Pixel bus, four bytes |
| sclk_o | output | 1 | Gated shift clock |
| vclk_o | output | 1 | Free-running video clock |
| nib_o | output | 16 | Captured nibbles, byte 3 in the top 4 bits |

## Verification
The divider is run at all five ratios and at one clamped setting. For each, the bench counts shift-clock and video-clock rises and high samples over a fixed window; this tells each ratio apart, and it shows whether blanking suppresses the shift clock. Blanking windows with a flag edge are repeated in every mode. Separate runs use a held flag, a flag that rises twice, and a flag edge during active video; together these show that exactly one pulse appears per edge and only in split mode. The upper and lower nibble choices use two pixel patterns, and the bench checks that `nib_o` changes only at a shift-clock rise and holds outside nibble mode.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    FLG_OFF    = 2'b00,
    FLG_SPLIT  = 2'b01,
    FLG_NIBBLE = 2'b10,
    FLG_BAD    = 2'b11
  } flag_mode_e;

  localparam int MAX_LOG = 4;
  localparam int DIV_W   = 3;
endpackage

// File: rtl/vsc_divider.sv
module vsc_divider
  import vsc_pkg::*;
#(
  parameter int MAX_LOG_P = MAX_LOG,
  parameter int DIV_W_P   = DIV_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W_P-1:0] div_sel_i,
  output logic               rise_evt_o,
  output logic               fall_evt_o,
  output logic               vclk_o
);
  localparam int CNT_W = (MAX_LOG_P > 0) ? MAX_LOG_P : 1;

  logic [DIV_W_P-1:0] sel_eff;
  logic [CNT_W:0]     span;
  logic [CNT_W-1:0]   last, cnt_q;
  logic               term, ph_q;

  always_comb begin
    sel_eff = (div_sel_i > DIV_W_P'(MAX_LOG_P)) ? DIV_W_P'(MAX_LOG_P) : div_sel_i;
    span    = (CNT_W+1)'(1) << sel_eff;
    last    = CNT_W'(span - 1'b1);
    // >= so a shrinking ratio ends the phase at once instead of wrapping
    term    = (cnt_q >= last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_evt_o = term & ~ph_q;
  assign fall_evt_o = term & ph_q;
  assign vclk_o     = ph_q;

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term |=> $stable(ph_q)); // R1
endmodule

// File: rtl/vsc_flag_sync.sv
module vsc_flag_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic level_o,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= flag_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R5
endmodule

// File: rtl/vsc_sclk_gate.sv
module vsc_sclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_evt_i,
  input  logic fall_evt_i,
  input  logic blank_i,
  input  logic split_en_i,
  input  logic flag_rise_i,
  output logic sclk_rise_o,
  output logic sclk_o
);
  logic sclk_q, pend_q, allow;

  always_comb begin
    allow       = !blank_i || pend_q;
    sclk_rise_o = rise_evt_i && allow;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // gate decided only at the rise, so every pulse is full width
      if (fall_evt_i)      sclk_q <= 1'b0;
      else if (rise_evt_i) sclk_q <= allow;

      if (!split_en_i || !blank_i) pend_q <= 1'b0;
      else if (flag_rise_i)        pend_q <= 1'b1;
      else if (rise_evt_i)         pend_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;

  AST_BLANK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !pend_q && !sclk_q) |=> !sclk_q); // R3
  AST_SPLIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !split_en_i |=> !pend_q); // R8
endmodule

// File: rtl/vsc_nibble_pick.sv
module vsc_nibble_pick #(
  parameter int PIX_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nib_en_i,
  input  logic               vclk_fall_i,
  input  logic               sclk_rise_i,
  input  logic               flag_lvl_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic [PIX_W/2-1:0] nib_o
);
  localparam int LANES = PIX_W / 8;

  logic                 hi_q;
  logic [PIX_W/2-1:0]   nib_q, nib_nxt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign nib_nxt[4*l +: 4] = hi_q ? pix_i[8*l+4 +: 4] : pix_i[8*l +: 4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      nib_q <= '0;
    end else if (nib_en_i) begin
      if (vclk_fall_i) hi_q  <= flag_lvl_i;
      if (sclk_rise_i) nib_q <= nib_nxt;
    end
  end

  assign nib_o = nib_q;

  AST_NIB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nib_en_i && sclk_rise_i) |=> $stable(nib_q)); // R7
endmodule

// File: rtl/vram_sclk_ctrl.sv
module vram_sclk_ctrl
  import vsc_pkg::*;
#(
  parameter int PIX_W     = 32,
  parameter int MAX_LOG_P = MAX_LOG,
  parameter int DIV_W_P   = DIV_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blank_i,
  input  logic [1:0]         mode_i,
  input  logic [DIV_W_P-1:0] div_sel_i,
  input  logic               flag_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic               sclk_o,
  output logic               vclk_o,
  output logic [PIX_W/2-1:0] nib_o
);
  flag_mode_e mode;
  logic rise_evt, fall_evt, flag_lvl, flag_rise, sclk_rise;
  logic split_en, nib_en;

  assign mode     = flag_mode_e'(mode_i);
  assign split_en = (mode == FLG_SPLIT);
  assign nib_en   = (mode == FLG_NIBBLE);

  vsc_divider #(.MAX_LOG_P(MAX_LOG_P), .DIV_W_P(DIV_W_P)) u_div (
    .clk_i, .rst_ni, .div_sel_i,
    .rise_evt_o(rise_evt), .fall_evt_o(fall_evt), .vclk_o
  );

  vsc_flag_sync u_sync (
    .clk_i, .rst_ni, .flag_i, .level_o(flag_lvl), .rise_o(flag_rise)
  );

  vsc_sclk_gate u_gate (
    .clk_i, .rst_ni,
    .rise_evt_i(rise_evt), .fall_evt_i(fall_evt), .blank_i,
    .split_en_i(split_en), .flag_rise_i(flag_rise),
    .sclk_rise_o(sclk_rise), .sclk_o
  );

  vsc_nibble_pick #(.PIX_W(PIX_W)) u_nib (
    .clk_i, .rst_ni, .nib_en_i(nib_en), .vclk_fall_i(fall_evt),
    .sclk_rise_i(sclk_rise), .flag_lvl_i(flag_lvl), .pix_i, .nib_o
  );

  AST_SCLK_INSIDE_VCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> vclk_o); // R2
endmodule

// File: tb/vram_sclk_ctrl_bench.sv
module vram_sclk_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        blank_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [2:0]  div_sel_i = 3'd0;
  logic        flag_i = 1'b0;
  logic [31:0] pix_i = '0;
  logic        sclk_o, vclk_o;
  logic [15:0] nib_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  vram_sclk_ctrl u_vram_sclk_ctrl (
    .clk_i, .rst_ni, .blank_i, .mode_i, .div_sel_i, .flag_i, .pix_i,
    .sclk_o, .vclk_o, .nib_o
  );

  typedef struct packed {
    logic [2:0] div;
    logic [1:0] mode;
    logic       blank;
    logic       flag;
    logic [7:0] s_rise;
    logic [7:0] s_high;
  } vec_t;

  // window of 128 dot cycles; flag rises at cycle 8 when set
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'b00, 1'b0, 1'b0, 8'd64, 8'd64},
    '{3'd1, 2'b00, 1'b0, 1'b0, 8'd32, 8'd64},
    '{3'd2, 2'b00, 1'b0, 1'b0, 8'd16, 8'd64},
    '{3'd3, 2'b00, 1'b0, 1'b0, 8'd8,  8'd64},
    '{3'd4, 2'b00, 1'b0, 1'b0, 8'd4,  8'd64},
    '{3'd7, 2'b00, 1'b0, 1'b0, 8'd4,  8'd64},
    '{3'd1, 2'b01, 1'b0, 1'b1, 8'd32, 8'd64},
    '{3'd2, 2'b00, 1'b1, 1'b0, 8'd0,  8'd0},
    '{3'd0, 2'b01, 1'b1, 1'b1, 8'd1,  8'd1},
    '{3'd2, 2'b01, 1'b1, 1'b1, 8'd1,  8'd4},
    '{3'd4, 2'b01, 1'b1, 1'b1, 8'd1,  8'd16},
    '{3'd3, 2'b00, 1'b1, 1'b1, 8'd0,  8'd0},
    '{3'd3, 2'b10, 1'b1, 1'b1, 8'd0,  8'd0},
    '{3'd3, 2'b11, 1'b1, 1'b1, 8'd0,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // counts shift rises, shift high samples, video rises over n cycles
  task automatic measure(input int n, input int f_up0, input int f_dn0,
                         input int f_up1, input int f_dn1,
                         output int sr, output int sh, output int vr);
    logic sp, vp;
    sr = 0; sh = 0; vr = 0;
    sp = sclk_o; vp = vclk_o;
    for (int i = 0; i < n; i++) begin
      if (i == f_up0 || i == f_up1) flag_i = 1'b1;
      if (i == f_dn0 || i == f_dn1) flag_i = 1'b0;
      @(negedge clk_i);
      if (sclk_o && !sp) sr++;
      if (vclk_o && !vp) vr++;
      if (sclk_o) sh++;
      sp = sclk_o; vp = vclk_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int sr, sh, vr, de;
    logic sp;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(sclk_o == 1'b0, "R9 sclk", sclk_o, 0);
    chk(vclk_o == 1'b0, "R9 vclk", vclk_o, 0);
    chk(nib_o == 16'h0, "R9 nib", nib_o, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      div_sel_i = VECS[v].div;
      mode_i    = VECS[v].mode;
      blank_i   = VECS[v].blank;
      flag_i    = 1'b0;
      repeat (64) @(negedge clk_i);
      if (VECS[v].flag) measure(128, 8, -1, -1, -1, sr, sh, vr);
      else              measure(128, -1, -1, -1, -1, sr, sh, vr);
      flag_i = 1'b0;
      de = (VECS[v].div > 3'd4) ? 4 : int'(VECS[v].div);
      // R1 video clock, R2/R3/R4/R5/R8 shift clock per vector
      chk(vr == (64 >> de), $sformatf("R1 vclk rises vec%0d", v), vr, 64 >> de);
      chk(sr == int'(VECS[v].s_rise), $sformatf("R2 R3 R4 R5 R8 sclk rises vec%0d", v),
          sr, VECS[v].s_rise);
      chk(sh == int'(VECS[v].s_high), $sformatf("R2 R4 sclk high vec%0d", v),
          sh, VECS[v].s_high);
    end

    // R5 two separate edges in one blanking interval
    div_sel_i = 3'd1; mode_i = 2'b01; blank_i = 1'b1; flag_i = 1'b0;
    repeat (64) @(negedge clk_i);
    measure(128, 4, 20, 40, 60, sr, sh, vr);
    chk(sr == 2, "R5 two edges rises", sr, 2);
    chk(sh == 4, "R5 two edges high", sh, 4);

    // R6 nibble selection
    blank_i = 1'b0; mode_i = 2'b10; div_sel_i = 3'd2;
    pix_i = 32'hA5C3_7E19; flag_i = 1'b1;
    repeat (80) @(negedge clk_i);
    chk(nib_o == 16'hAC71, "R6 upper nibbles", nib_o, 16'hAC71);
    flag_i = 1'b0;
    repeat (80) @(negedge clk_i);
    chk(nib_o == 16'h53E9, "R6 lower nibbles", nib_o, 16'h53E9);

    // R7 capture only at an sclk rise
    div_sel_i = 3'd4; flag_i = 1'b1; pix_i = 32'h1234_5678;
    repeat (80) @(negedge clk_i);
    chk(nib_o == 16'h1357, "R6 upper nibbles pattern 2", nib_o, 16'h1357);
    sp = sclk_o;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      if (sclk_o && !sp) break;
      sp = sclk_o;
    end
    pix_i = 32'hA5C3_7E19;
    repeat (10) @(negedge clk_i);
    chk(nib_o == 16'h1357, "R7 held between sclk rises", nib_o, 16'h1357);
    repeat (40) @(negedge clk_i);
    chk(nib_o == 16'hAC71, "R7 updated at next sclk rise", nib_o, 16'hAC71);

    // R7 hold outside nibble mode, R8 mode 11 captures nothing
    mode_i = 2'b00; pix_i = 32'h1234_5678;
    repeat (80) @(negedge clk_i);
    chk(nib_o == 16'hAC71, "R7 hold in mode 00", nib_o, 16'hAC71);
    mode_i = 2'b11; flag_i = 1'b0;
    repeat (80) @(negedge clk_i);
    chk(nib_o == 16'hAC71, "R8 hold in mode 11", nib_o, 16'hAC71);

    // R9 reset returns outputs to zero
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(nib_o == 16'h0 && !sclk_o && !vclk_o, "R9 reset again", nib_o, 0);

    summary();
  end
endmodule